// File: doc/BRIEF.md
# Sequential Multiply-Divide Unit with HI/LO Result Registers

This block performs 32-bit integer multiplication and division over many clock cycles and leaves each answer in a pair of dedicated result registers, HI and LO. These registers sit apart from the host's general-purpose registers. A host issues an operation by raising `start` for one cycle with an operation code and two operands. The unit then iterates one bit per cycle. Multiplication uses shift-and-add on operand magnitudes. Division uses restoring subtraction, also on magnitudes. A final cycle applies the signs and writes HI and LO together. The host reads the pair at any time through two read ports that play the role of move-from-HI and move-from-LO.

Multiply and divide share the one register pair, with a fixed placement for each. A product puts its upper half in HI and its lower half in LO. A division puts the remainder in HI and the quotient in LO. The unit raises no overflow indication of any kind, so software must inspect HI itself when it needs to know. Division by zero completes normally and leaves defined values.

The controller is a three-state machine:
- `S_IDLE` waits for work. It moves to `S_RUN` when `start` is high.
- `S_RUN` performs one iteration per cycle while a counter goes from 0 to 31. It stays in `S_RUN` until the 32nd iteration, then moves to `S_FIN`.
- `S_FIN` writes HI and LO and always returns to `S_IDLE`. The cycle after `S_FIN` shows a one-cycle `done` pulse.

Top module: `mdu_unit`

## Requirements
- R1: After reset, HI and LO read zero, and `busy` and `done` are low.
- R2: A `start` seen while idle is accepted. `busy` is high from the next cycle until the result is written. `done` is high for exactly one cycle, 33 clock edges after the accepting edge, and `busy` is low in that cycle.
- R3: Operation code 2'b00 is signed multiply and 2'b01 is unsigned multiply. Afterwards, HI holds bits 63:32 and LO holds bits 31:0 of the full 64-bit product.
- R4: Signed multiply reads operands as two's complement and unsigned multiply reads them as plain binary, so the same bit patterns give different results (for example 0xFFFFFFFF squared).
- R5: Operation code 2'b10 is signed divide and 2'b11 is unsigned divide. Afterwards, LO holds the quotient and HI holds the remainder, and for unsigned divide quotient × divisor + remainder equals the dividend.
- R6: A signed divide truncates the quotient toward zero, and its remainder has the sign of the dividend.
- R7: Dividing by zero completes with normal timing and leaves LO = 0xFFFFFFFF and HI = the dividend, for both signed and unsigned divide.
- R8: No overflow is detected. Signed 0x80000000 / 0xFFFFFFFF gives LO = 0x80000000 and HI = 0, and large products simply fill HI.
- R9: A `start` that arrives while `busy` is high is ignored. The running operation keeps its timing and its result.
- R10: HI and LO keep their values in every cycle in which `done` is low, and both change together, becoming visible in the `done` cycle.
- R11: Operands and the operation code are sampled only on the accepting edge. Later changes on those inputs do not affect the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to begin an operation |
| op | input | 2 | Operation: 00 signed mul, 01 unsigned mul, 10 signed div, 11 unsigned div |
| opa | input | 32 | Multiplicand or dividend |
| opb | input | 32 | Multiplier or divisor |
| busy | output | 1 | High while an operation is in progress |
| done | output | 1 | One-cycle pulse when HI/LO receive a new result |
| hi_rd | output | 32 | Read port of HI |
| lo_rd | output | 32 | Read port of LO |

## Verification
Each operation runs on the same operand pattern under both signed and unsigned codes, such as all-ones times all-ones, so a mix-up in operand interpretation shows up directly. Divisions cover all four sign combinations of dividend and divisor. These cases separate truncation toward zero from floor rounding, and expose a remainder that takes the wrong sign. Boundary patterns cover:
- the most negative value squared;
- the most negative value divided by minus one;
- a dividend smaller than the divisor;
- division of an all-ones dividend by one;
- division by zero under both codes.

Each boundary pattern targets a corner that magnitude handling or sign fix-up could get wrong. Further runs scramble the inputs after acceptance and pulse `start` mid-operation, which shows that only the accepting edge matters.

// File: rtl/mdu_pkg.sv
package mdu_pkg;

    localparam int unsigned MDU_W = 32;

    typedef enum logic [1:0] {
        OP_MULS = 2'b00,
        OP_MULU = 2'b01,
        OP_DIVS = 2'b10,
        OP_DIVU = 2'b11
    } mdu_op_e;

    typedef enum logic [1:0] {
        S_IDLE = 2'b00,
        S_RUN  = 2'b01,
        S_FIN  = 2'b10
    } mdu_state_e;

endpackage

// File: rtl/mdu_prep.sv
// Converts operands to magnitudes and derives the sign corrections
// that the final cycle applies.
module mdu_prep #(
    parameter int unsigned W = 32
) (
    input  logic [1:0]   op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] mag_a,
    output logic [W-1:0] mag_b,
    output logic         neg_main,
    output logic         neg_rem
);
    logic is_signed;
    logic sa;
    logic sb;

    always_comb begin
        // bit 0 low selects the signed variant of both multiply and divide
        is_signed = ~op[0];
        sa        = is_signed & a[W-1];
        sb        = is_signed & b[W-1];
        mag_a     = sa ? (~a + 1'b1) : a;
        mag_b     = sb ? (~b + 1'b1) : b;
        neg_main  = sa ^ sb;
        neg_rem   = sa;
    end
endmodule

// File: rtl/mdu_step.sv
// One iteration of either shift-and-add multiply or restoring divide.
module mdu_step #(
    parameter int unsigned W = 32
) (
    input  logic         is_div,
    input  logic [W:0]   hi,
    input  logic [W-1:0] lo,
    input  logic [W-1:0] b,
    output logic [W:0]   nhi,
    output logic [W-1:0] nlo
);
    logic [W:0]   addend;
    logic [W:0]   sum;
    logic [W:0]   shifted;
    logic [W+1:0] diff;
    logic         qbit;

    always_comb begin
        // multiply path: conditional add, then shift the pair right
        addend  = lo[0] ? {1'b0, b} : '0;
        sum     = hi + addend;
        // divide path: shift the pair left, trial subtract
        shifted = {hi[W-1:0], lo[W-1]};
        diff    = {1'b0, shifted} - {2'b00, b};
        qbit    = ~diff[W+1];
        if (is_div) begin
            nhi = qbit ? diff[W:0] : shifted;
            nlo = {lo[W-2:0], qbit};
        end else begin
            nhi = {1'b0, sum[W:1]};
            nlo = {sum[0], lo[W-1:1]};
        end
    end
endmodule

// File: rtl/mdu_ctrl.sv
module mdu_ctrl
    import mdu_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done,
    output logic load,
    output logic step,
    output logic fin
);
    localparam int unsigned CW   = $clog2(W);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    mdu_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          done_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            cnt_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            done_q  <= (state_q == S_FIN);
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            S_IDLE: begin
                cnt_d = '0;
                if (start) state_d = S_RUN;
            end
            S_RUN: begin
                cnt_d = cnt_q + 1'b1;
                if (cnt_q == LAST) state_d = S_FIN;
            end
            S_FIN: state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_comb begin
        busy = 1'b0;
        load = 1'b0;
        step = 1'b0;
        fin  = 1'b0;
        unique case (state_q)
            S_IDLE: load = start;
            S_RUN: begin
                busy = 1'b1;
                step = 1'b1;
            end
            S_FIN: begin
                busy = 1'b1;
                fin  = 1'b1;
            end
            default: ;
        endcase
    end

    assign done = done_q;

    // done is a single-cycle pulse and never overlaps busy
    assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_done_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    // the iteration counter advances regardless of any start while running
    assert_run_advance_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RUN && cnt_q != LAST) |=>
            (state_q == S_RUN && cnt_q == $past(cnt_q) + CW'(1)));
endmodule

// File: rtl/mdu_unit.sv
module mdu_unit
    import mdu_pkg::*;
#(
    parameter int unsigned W = MDU_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [1:0]   op,
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] hi_rd,
    output logic [W-1:0] lo_rd
);
    localparam int unsigned PW = 2 * W;

    logic load, step, fin;
    logic [W-1:0] mag_a, mag_b;
    logic neg_main, neg_rem;

    logic [W:0]   wk_hi, nhi;
    logic [W-1:0] wk_lo, nlo, wk_b;
    mdu_op_e      op_q;
    logic [W-1:0] a_q, b_q;
    logic         negm_q, negr_q;
    logic [W-1:0] hi_q, lo_q;

    logic [PW-1:0] prod, prod_s;
    logic [W-1:0]  quo, rem, res_hi, res_lo;

    mdu_ctrl #(.W(W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start),
        .busy(busy), .done(done), .load(load), .step(step), .fin(fin)
    );

    mdu_prep #(.W(W)) u_prep (
        .op(op), .a(opa), .b(opb),
        .mag_a(mag_a), .mag_b(mag_b), .neg_main(neg_main), .neg_rem(neg_rem)
    );

    mdu_step #(.W(W)) u_step (
        .is_div(op_q[1]), .hi(wk_hi), .lo(wk_lo), .b(wk_b),
        .nhi(nhi), .nlo(nlo)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wk_hi  <= '0;
            wk_lo  <= '0;
            wk_b   <= '0;
            op_q   <= OP_MULS;
            a_q    <= '0;
            b_q    <= '0;
            negm_q <= 1'b0;
            negr_q <= 1'b0;
            hi_q   <= '0;
            lo_q   <= '0;
        end else begin
            if (load) begin
                wk_hi  <= '0;
                wk_lo  <= mag_a;
                wk_b   <= mag_b;
                op_q   <= mdu_op_e'(op);
                a_q    <= opa;
                b_q    <= opb;
                negm_q <= neg_main;
                negr_q <= neg_rem;
            end else if (step) begin
                wk_hi <= nhi;
                wk_lo <= nlo;
            end
            if (fin) begin
                hi_q <= res_hi;
                lo_q <= res_lo;
            end
        end
    end

    // sign fix-up and placement into the shared pair
    always_comb begin
        prod   = {wk_hi[W-1:0], wk_lo};
        prod_s = negm_q ? (~prod + 1'b1) : prod;
        quo    = negm_q ? (~wk_lo + 1'b1) : wk_lo;
        rem    = negr_q ? (~wk_hi[W-1:0] + 1'b1) : wk_hi[W-1:0];
        if (b_q == '0) quo = '1;
        if (op_q[1]) begin
            res_hi = rem;
            res_lo = quo;
        end else begin
            res_hi = prod_s[PW-1:W];
            res_lo = prod_s[W-1:0];
        end
    end

    assign hi_rd = hi_q;
    assign lo_rd = lo_q;

    assert_pair_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(hi_q) && $stable(lo_q)));
    assert_mulu_product_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op_q == OP_MULU) |->
            ({hi_q, lo_q} == {{W{1'b0}}, a_q} * {{W{1'b0}}, b_q}));
    assert_divu_identity_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op_q == OP_DIVU && b_q != '0) |->
            (({{W{1'b0}}, lo_q} * {{W{1'b0}}, b_q} + {{W{1'b0}}, hi_q})
                == {{W{1'b0}}, a_q} && hi_q < b_q));
    assert_div_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op_q[1] && b_q == '0) |-> (lo_q == '1 && hi_q == a_q));
endmodule

// File: tb/tb_mdu_unit.sv
module tb_mdu_unit;
    localparam int CLK_PERIOD = 10;
    localparam int LATENCY    = 33;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  op_i = 2'b00;
    logic [31:0] a_i = '0, b_i = '0;
    logic        busy, done;
    logic [31:0] hi, lo;

    int n_checks = 0;
    int n_fail   = 0;

    mdu_unit dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op_i),
        .opa(a_i), .opb(b_i), .busy(busy), .done(done),
        .hi_rd(hi), .lo_rd(lo)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        #(CLK_PERIOD * 20000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: run did not finish (actual hung, expected done)");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic expect_of(input logic [1:0] o, input logic [31:0] a, input logic [31:0] b,
                             output logic [31:0] eh, output logic [31:0] el);
        longint sa, sb, sp, sq, sr;
        logic [63:0] up;
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        case (o)
            2'b00: begin sp = sa * sb; eh = sp[63:32]; el = sp[31:0]; end
            2'b01: begin up = {32'b0, a} * {32'b0, b}; eh = up[63:32]; el = up[31:0]; end
            2'b10: begin
                if (b == 0) begin eh = a; el = '1; end
                else begin sq = sa / sb; sr = sa % sb; eh = sr[31:0]; el = sq[31:0]; end
            end
            default: begin
                if (b == 0) begin eh = a; el = '1; end
                else begin eh = a % b; el = a / b; end
            end
        endcase
    endtask

    // issues one operation; scrambles inputs after acceptance (R11),
    // optionally pokes start while busy (R9)
    task automatic run_op(input logic [1:0] o, input logic [31:0] a, input logic [31:0] b,
                          input bit poke, input string tag);
        logic [31:0] eh, el, hold_hi, hold_lo;
        int n;
        bit ok_busy, ok_hold;
        expect_of(o, a, b, eh, el);
        @(negedge clk);
        start = 1'b1; op_i = o; a_i = a; b_i = b;
        @(negedge clk);
        start = 1'b0; op_i = ~o; a_i = ~a; b_i = a ^ 32'h5A5A_0F0F;
        n = 0; ok_busy = 1; ok_hold = 1;
        hold_hi = hi; hold_lo = lo;
        while (!done && n < 100) begin
            if (!busy) ok_busy = 0;
            if (hi !== hold_hi || lo !== hold_lo) ok_hold = 0;
            start = (poke && (n == 4 || n == 31 || n == 32));
            @(negedge clk);
            n++;
        end
        start = 1'b0;
        chk({tag, " R2 latency"}, n, LATENCY);
        chk({tag, " R2 busy while running"}, ok_busy, 1);
        chk({tag, " R10 HI/LO held until done"}, ok_hold, 1);
        chk({tag, " R2 busy low at done"}, busy, 0);
        chk({tag, " HI"}, hi, eh);
        chk({tag, " LO"}, lo, el);
        @(negedge clk);
        chk({tag, " R2 done single pulse"}, done, 0);
        chk({tag, " R9 no restart after poke"}, busy, 0);
        chk({tag, " R10 HI kept"}, hi, eh);
    endtask

    task automatic t_reset;
        chk("R1 HI reset", hi, 0);
        chk("R1 LO reset", lo, 0);
        chk("R1 busy reset", busy, 0);
        chk("R1 done reset", done, 0);
    endtask

    task automatic t_mul_unsigned;
        run_op(2'b01, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, "R3 R4 mulu ones");
        run_op(2'b01, 32'h1234_5678, 32'h9ABC_DEF0, 0, "R3 mulu mixed");
        run_op(2'b01, 32'h0000_0000, 32'hDEAD_BEEF, 0, "R3 mulu zero");
    endtask

    task automatic t_mul_signed;
        run_op(2'b00, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, "R4 muls minus one sq");
        run_op(2'b00, 32'd7, 32'hFFFF_FFFD, 0, "R3 muls 7x-3");
        run_op(2'b00, 32'h8000_0000, 32'h8000_0000, 0, "R8 muls min sq");
    endtask

    task automatic t_div_signs;
        run_op(2'b11, 32'd100, 32'd7, 0, "R5 divu 100/7");
        run_op(2'b11, 32'd5, 32'd9, 0, "R5 divu small");
        run_op(2'b11, 32'hFFFF_FFFF, 32'd1, 0, "R5 divu by one");
        run_op(2'b10, 32'hFFFF_FFF9, 32'd2, 0, "R6 divs -7/2");
        run_op(2'b10, 32'd7, 32'hFFFF_FFFE, 0, "R6 divs 7/-2");
        run_op(2'b10, 32'hFFFF_FFF9, 32'hFFFF_FFFE, 0, "R6 divs -7/-2");
        run_op(2'b11, 32'hFFFF_FFF9, 32'd2, 0, "R5 divu same bits");
    endtask

    task automatic t_div_zero;
        run_op(2'b11, 32'd123, 32'd0, 0, "R7 divu by zero");
        run_op(2'b10, 32'hFFFF_FFFB, 32'd0, 0, "R7 divs by zero");
    endtask

    task automatic t_no_overflow;
        run_op(2'b10, 32'h8000_0000, 32'hFFFF_FFFF, 0, "R8 divs min/-1");
    endtask

    task automatic t_busy_ignore;
        run_op(2'b00, 32'h0001_0003, 32'hFFF0_0011, 1, "R9 R11 muls poked");
        run_op(2'b11, 32'hCAFE_F00D, 32'h0000_0123, 1, "R9 R11 divu poked");
    endtask

    initial begin
        #(CLK_PERIOD * 3 + 2);
        t_reset;
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_mul_unsigned;
        t_mul_signed;
        t_div_signs;
        t_div_zero;
        t_no_overflow;
        t_busy_ignore;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule